// File: doc/BRIEF.md
# Sync Mark Hunter with Run-Length Guard

This block sits behind a read channel's clock recovery loop. Once the loop reports lock on the preamble, the block takes one encoded bit per bit-enable strobe. It passes over the alternating preamble and waits for the first place where two equal bits follow each other. That place is three bits before the end of a correct mark. Three bits later it compares the six most recent bits with the mark `100100`. It then reports exactly one outcome: mark found, mark damaged, or no decision inside the timeout window.

After a clean mark, a run-length guard watches the data that follows. It checks that every one bit is separated from the previous one by one to seven zeros, and it keeps doing so until software-independent control logic pulses a clear input. The hunt re-arms only after the lock input falls and rises again. A synchronous active-low reset returns everything to idle.

Top module: `sync_mark_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four outputs are 0 after that edge, the hunt returns to idle and the run-length guard becomes inactive.
- R2: Bits are taken only in cycles where `bit_en_i` is 1. The value on `bit_i` in any other cycle has no effect on any output.
- R3: After lock rises, alternating preamble bits raise nothing. When the first two equal consecutive bits are followed by three more bits, and the last six bits received (oldest first) equal `100100`, `sync_found_o` pulses.
- R4: At that same decision point, if the last six bits differ from `100100` (a dropped, inserted or shifted bit), `sync_err_o` pulses instead of `sync_found_o`.
- R5: If no decision has been made by the TIMEOUT_BITS-th bit taken since the hunt began (default 64), `sync_tmo_o` pulses on that bit. A decision made on that same bit takes precedence over the timeout.
- R6: Every output pulse is one clock cycle long and appears in the cycle after the edge that takes the deciding bit. At most one of `sync_found_o`, `sync_err_o` and `sync_tmo_o` is high in any cycle.
- R7: After any of the three hunt outcomes, no further hunt outcome appears until `lock_i` has been low for at least one cycle and has risen again. If lock falls during a hunt, the hunt is dropped with no pulse, and the next hunt starts from an empty history.
- R8: From the edge that takes a clean mark's last bit, and until cleared, `rl_viol_o` pulses after a one bit that directly follows a one bit. It also pulses after the eighth consecutive zero, counting the mark's two trailing zeros. A longer run flags only once.
- R9: A cycle with `rl_clear_i` high deactivates the run-length guard. No violation is reported afterwards until the next clean mark. The clear takes precedence over a mark found in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Clock recovery loop locked on preamble |
| bit_en_i | input | 1 | Strobe: take `bit_i` this cycle |
| bit_i | input | 1 | Encoded read bit |
| rl_clear_i | input | 1 | Stop run-length checking |
| sync_found_o | output | 1 | Clean mark pulse |
| sync_err_o | output | 1 | Damaged mark pulse |
| sync_tmo_o | output | 1 | No-decision timeout pulse |
| rl_viol_o | output | 1 | Run-length violation pulse |

## Verification
The bench targets the preamble-to-mark boundary with an inserted zero, a missing zero and a doubled one. A design that compares at the wrong moment, or matches the pattern anywhere in the stream, would report found or nothing in these cases instead of an error. A clean mark is placed so that it ends exactly on the timeout bit; a design that gives the timeout priority would report a timeout there. Lock is dropped halfway through a hunt, and the bench expects silence followed by a clean restart. A design with stale history would report the mark too early. The run-length checks cover a zero-free `11`, exactly seven zeros, the eighth zero, a ninth zero that must stay quiet, and checking after a clear. Noise on `bit_i` between strobes catches any logic that does not gate on the strobe.

// File: rtl/sm_sync_pkg.sv
// Package: shared types and helpers for the sync mark hunter.
// Assumes: sync patterns no wider than 32 bits.
package sm_sync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_DONE = 2'd2
    } hunt_state_t;

    // Number of zero bits at the newest end of a pattern of width w.
    function automatic int trailing_zeros(input logic [31:0] pat, input int w);
        int n;
        logic stop;
        n = 0;
        stop = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (i < w && !stop) begin
                if (pat[i] == 1'b0) n = n + 1;
                else stop = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/sm_bit_window.sv
// Module: keeps the recent bit history and flags a break in alternation.
// Assumes: MARK_W >= 2; clr is held while no hunt is running.
module sm_bit_window #(
    parameter int MARK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [MARK_W-1:0] win_next,
    output logic              dev
);
    localparam int HIST_W = MARK_W - 1;

    logic [HIST_W-1:0] hist;
    logic              have_prev;

    // Window including the bit offered this cycle, newest bit at LSB.
    assign win_next = {hist, bit_in};
    // Deviation: the taken bit equals the bit before it.
    assign dev = bit_en && have_prev && (bit_in == hist[0]);

    // Shift history on each strobe; empty it when no hunt runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist      <= '0;
            have_prev <= 1'b0;
        end else if (bit_en) begin
            hist      <= win_next[HIST_W-1:0];
            have_prev <= 1'b1;
        end
    end

    // R2: without a strobe the history does not move.
    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !clr) |=> $stable(hist));

endmodule

// File: rtl/sm_hunt_ctrl.sv
// Module: hunt state machine, decision point, timeout window.
// Assumes: TAIL_BITS is the number of mark bits after the first pair of
// equal bits (3 for 100100); TIMEOUT >= 1.
module sm_hunt_ctrl
    import sm_sync_pkg::*;
#(
    parameter int              MARK_W    = 6,
    parameter logic [MARK_W-1:0] SYNC_PAT = 6'b100100,
    parameter int              TAIL_BITS = 3,
    parameter int              TIMEOUT   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              bit_en,
    input  logic              dev,
    input  logic [MARK_W-1:0] win_next,
    output logic              win_clr,
    output logic              mark_hit,
    output logic              found,
    output logic              err,
    output logic              tmo
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam int REM_W = $clog2(TAIL_BITS + 1);

    hunt_state_t      state;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] cnt_nx;
    logic [REM_W-1:0] rem;
    logic             armed;
    logic             take;
    logic             decide;
    logic             mark_miss;
    logic             tmo_hit;

    assign win_clr = (state != ST_HUNT);

    // Decide outcome for the bit taken this cycle.
    always_comb begin
        take      = (state == ST_HUNT) && lock && bit_en;
        cnt_nx    = bit_cnt + 1'b1;
        decide    = take && armed && (rem == REM_W'(1));
        mark_hit  = decide && (win_next == SYNC_PAT);
        mark_miss = decide && (win_next != SYNC_PAT);
        tmo_hit   = take && !decide && (cnt_nx == CNT_W'(TIMEOUT));
    end

    // State, counters and registered one-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rem     <= '0;
            armed   <= 1'b0;
            found   <= 1'b0;
            err     <= 1'b0;
            tmo     <= 1'b0;
        end else begin
            found <= mark_hit;
            err   <= mark_miss;
            tmo   <= tmo_hit;
            case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    rem     <= '0;
                    armed   <= 1'b0;
                    if (lock) state <= ST_HUNT;
                end
                ST_HUNT: begin
                    if (!lock) begin
                        state <= ST_IDLE;
                    end else if (mark_hit || mark_miss || tmo_hit) begin
                        state <= ST_DONE;
                    end else if (bit_en) begin
                        bit_cnt <= cnt_nx;
                        if (armed) begin
                            rem <= rem - 1'b1;
                        end else if (dev) begin
                            armed <= 1'b1;
                            rem   <= REM_W'(TAIL_BITS);
                        end
                    end
                end
                ST_DONE: begin
                    if (!lock) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: outcomes exclusive and one cycle long.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({found, err, tmo}));
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (found || err || tmo) |=> !(found || err || tmo));
    // R7: a finished hunt stays quiet.
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> !(found || err || tmo));
    // R5: bit counter never passes the window during a hunt.
    a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> (bit_cnt < CNT_W'(TIMEOUT)));
    // R5: a timeout comes only from a running hunt.
    a_r5_tmo_from_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> ($past(state) == ST_HUNT));

endmodule

// File: rtl/sm_runlen_chk.sv
// Module: run-length guard for the encoded data after a clean mark.
// Assumes: start is a one-cycle pulse on the edge taking the mark's last
// bit; SEED_ZEROS is the number of zeros ending the mark.
module sm_runlen_chk #(
    parameter int MAX_ZEROS  = 7,
    parameter int SEED_ZEROS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    input  logic bit_en,
    input  logic bit_in,
    output logic viol
);
    localparam int ZW = $clog2(MAX_ZEROS + 2);

    logic          active;
    logic [ZW-1:0] zcnt;

    // Track zeros since the last one bit and flag both run limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            zcnt   <= '0;
            viol   <= 1'b0;
        end else begin
            viol <= 1'b0;
            if (clear) begin
                active <= 1'b0;
            end else if (start) begin
                active <= 1'b1;
                zcnt   <= ZW'(SEED_ZEROS);
            end else if (active && bit_en) begin
                if (bit_in) begin
                    viol <= (zcnt == '0);
                    zcnt <= '0;
                end else begin
                    if (zcnt == ZW'(MAX_ZEROS)) viol <= 1'b1;
                    if (zcnt <= ZW'(MAX_ZEROS)) zcnt <= zcnt + 1'b1;
                end
            end
        end
    end

    // R8: a violation needs an armed guard.
    a_r8_viol_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(active));
    // R8: zero counter saturates one above the limit.
    a_r8_zcnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        zcnt <= ZW'(MAX_ZEROS + 1));
    // R9: a clear leaves the guard idle and silent.
    a_r9_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!active && !viol));

endmodule

// File: rtl/sync_mark_detect.sv
// Module: top of the sync mark hunter; wires history, hunt control and
// run-length guard. Assumes one bit per bit_en_i strobe, inputs synchronous.
module sync_mark_detect
    import sm_sync_pkg::*;
#(
    parameter int                MARK_W       = 6,
    parameter logic [MARK_W-1:0] SYNC_PAT     = 6'b100100,
    parameter int                TAIL_BITS    = 3,
    parameter int                TIMEOUT_BITS = 64,
    parameter int                MAX_ZERO_RUN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    input  logic bit_en_i,
    input  logic bit_i,
    input  logic rl_clear_i,
    output logic sync_found_o,
    output logic sync_err_o,
    output logic sync_tmo_o,
    output logic rl_viol_o
);
    localparam int SEED_ZEROS = trailing_zeros(32'(SYNC_PAT), MARK_W);

    logic [MARK_W-1:0] win_next;
    logic              dev;
    logic              win_clr;
    logic              mark_hit;

    sm_bit_window #(.MARK_W(MARK_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (win_clr),
        .bit_en   (bit_en_i),
        .bit_in   (bit_i),
        .win_next (win_next),
        .dev      (dev)
    );

    sm_hunt_ctrl #(
        .MARK_W    (MARK_W),
        .SYNC_PAT  (SYNC_PAT),
        .TAIL_BITS (TAIL_BITS),
        .TIMEOUT   (TIMEOUT_BITS)
    ) u_hunt (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock     (lock_i),
        .bit_en   (bit_en_i),
        .dev      (dev),
        .win_next (win_next),
        .win_clr  (win_clr),
        .mark_hit (mark_hit),
        .found    (sync_found_o),
        .err      (sync_err_o),
        .tmo      (sync_tmo_o)
    );

    sm_runlen_chk #(
        .MAX_ZEROS  (MAX_ZERO_RUN),
        .SEED_ZEROS (SEED_ZEROS)
    ) u_runlen (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (mark_hit),
        .clear  (rl_clear_i),
        .bit_en (bit_en_i),
        .bit_in (bit_i),
        .viol   (rl_viol_o)
    );

    // R1: outputs quiet right after reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !(sync_found_o || sync_err_o || sync_tmo_o || rl_viol_o));

endmodule

// File: tb/sync_mark_detect_tb_top.sv
// Scoreboard bench: the driver queues the expected pulse vector
// {found, err, tmo, viol} per bit; the monitor compares one cycle later.
module sync_mark_detect_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_i = 1'b0;
    logic bit_en_i = 1'b0;
    logic bit_i = 1'b0;
    logic rl_clear_i = 1'b0;
    logic sync_found_o, sync_err_o, sync_tmo_o, rl_viol_o;

    int tests = 0;
    int fails = 0;
    logic due = 1'b0;
    logic [3:0] expq[$];
    string tagq[$];

    always #2 clk = ~clk;

    sync_mark_detect dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_i       (lock_i),
        .bit_en_i     (bit_en_i),
        .bit_i        (bit_i),
        .rl_clear_i   (rl_clear_i),
        .sync_found_o (sync_found_o),
        .sync_err_o   (sync_err_o),
        .sync_tmo_o   (sync_tmo_o),
        .rl_viol_o    (rl_viol_o)
    );

    wire [3:0] got = {sync_found_o, sync_err_o, sync_tmo_o, rl_viol_o};

    // Mark which negedge carries the result of a taken bit.
    always @(posedge clk) due <= bit_en_i;

    // Monitor: compare queued expectations; otherwise outputs must be idle.
    always @(negedge clk) begin
        if (due) begin
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: actual %b expected none", got);
            end else begin
                logic [3:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                tests++;
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s: actual %b expected %b", t, got, e);
                end
            end
        end else if (rst_n && got !== 4'b0000) begin
            tests++;
            fails++;
            $display("FAIL R6: stray pulse actual %b expected 0000", got);
        end
    end

    // Driver: one bit, then a gap cycle with noise on bit_i (R2).
    task automatic send_bit(input logic b, input logic [3:0] e, input string t);
        @(negedge clk);
        bit_en_i = 1'b1;
        bit_i    = b;
        expq.push_back(e);
        tagq.push_back(t);
        @(negedge clk);
        bit_en_i = 1'b0;
        bit_i    = ~b;
    endtask

    task automatic send_pre(input int n, input string t);
        for (int i = 0; i < n; i++) send_bit((i % 2) == 0, 4'b0000, t);
    endtask

    task automatic relock();
        @(negedge clk); lock_i = 1'b0;
        repeat (2) @(negedge clk);
        lock_i = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); rl_clear_i = 1'b1;
        @(negedge clk); rl_clear_i = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        tests++;
        if (got !== 4'b0000) begin
            fails++;
            $display("FAIL R1: reset outputs actual %b expected 0000", got);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3: clean mark after preamble; R2 noise between strobes.
        lock_i = 1'b1;
        repeat (2) @(negedge clk);
        send_pre(20, "R3 preamble");
        send_bit(1, 4'b0000, "R3"); send_bit(0, 4'b0000, "R3");
        send_bit(0, 4'b0000, "R3"); send_bit(1, 4'b0000, "R3");
        send_bit(0, 4'b0000, "R3"); send_bit(0, 4'b1000, "R3 found");

        // R8: run-length after mark (two zeros seeded).
        for (int i = 0; i < 5; i++) send_bit(0, 4'b0000, "R8 seven zeros");
        send_bit(1, 4'b0000, "R8");
        send_bit(0, 4'b0000, "R8");
        send_bit(1, 4'b0000, "R8");
        send_bit(1, 4'b0001, "R8 adjacent ones");
        for (int i = 0; i < 7; i++) send_bit(0, 4'b0000, "R8 zeros");
        send_bit(0, 4'b0001, "R8 eighth zero");
        send_bit(0, 4'b0000, "R8 flagged once");
        send_bit(1, 4'b0000, "R8 / R7 quiet after found");

        // R9: cleared guard ignores violations.
        pulse_clear();
        send_bit(1, 4'b0000, "R9");
        send_bit(1, 4'b0000, "R9 after clear");

        // R4: inserted zero (1000100).
        relock();
        send_pre(16, "R4 preamble");
        send_bit(1, 4'b0000, "R4"); send_bit(0, 4'b0000, "R4");
        send_bit(0, 4'b0000, "R4"); send_bit(0, 4'b0000, "R4");
        send_bit(1, 4'b0000, "R4"); send_bit(0, 4'b0100, "R4 inserted bit");
        send_bit(0, 4'b0000, "R7 quiet after err");

        // R4: missing zero (10010 then 1).
        relock();
        send_pre(12, "R4 preamble");
        send_bit(1, 4'b0000, "R4"); send_bit(0, 4'b0000, "R4");
        send_bit(0, 4'b0000, "R4"); send_bit(1, 4'b0000, "R4");
        send_bit(0, 4'b0000, "R4"); send_bit(1, 4'b0100, "R4 dropped bit");

        // R4: doubled one (..0 1 1 0 0 1).
        relock();
        send_pre(10, "R4 preamble");
        send_bit(1, 4'b0000, "R4"); send_bit(1, 4'b0000, "R4");
        send_bit(0, 4'b0000, "R4"); send_bit(0, 4'b0000, "R4");
        send_bit(1, 4'b0100, "R4 shifted bit");

        // R5: mark ending exactly on bit 64 wins over timeout.
        relock();
        send_pre(58, "R5 preamble");
        send_bit(1, 4'b0000, "R5"); send_bit(0, 4'b0000, "R5");
        send_bit(0, 4'b0000, "R5"); send_bit(1, 4'b0000, "R5");
        send_bit(0, 4'b0000, "R5"); send_bit(0, 4'b1000, "R5 decision beats timeout");
        pulse_clear();

        // R7: lock drop mid-hunt aborts silently, restart is fresh.
        relock();
        send_pre(10, "R7 preamble");
        send_bit(1, 4'b0000, "R7"); send_bit(0, 4'b0000, "R7");
        send_bit(0, 4'b0000, "R7 armed");
        relock();
        send_bit(1, 4'b0000, "R7 fresh"); send_bit(0, 4'b0000, "R7 fresh");
        send_bit(0, 4'b0000, "R7 fresh"); send_bit(1, 4'b0000, "R7 fresh");
        send_bit(0, 4'b0000, "R7 fresh"); send_bit(0, 4'b1000, "R7 restart found");
        pulse_clear();

        // R5: pure preamble times out on bit 64; R7 silence afterwards.
        relock();
        send_pre(63, "R5 preamble");
        send_bit(0, 4'b0010, "R5 timeout");
        send_pre(4, "R7 quiet after timeout");

        // R1: reset mid-hunt clears history.
        relock();
        send_pre(4, "R1 preamble");
        send_bit(0, 4'b0000, "R1 armed");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send_bit(1, 4'b0000, "R1 after reset");
        send_bit(0, 4'b0000, "R1 after reset");
        send_bit(0, 4'b0000, "R1 after reset");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule